// File: doc/BRIEF.md
# Silicon Test Loop Controller

This block sits between a chip tester and a signal-processing core during silicon bring-up and power measurement. It steps through three phases. In the first, the tester fills the core's working memory over an external port. In the second, the core processes that memory, either once or repeatedly with no external traffic, so that supply current can settle and be measured. In the third, the tester reads the results back out of the same memory.

A configuration register selects single-pass or continuous operation and holds one clock-enable bit per sub-block. The enable mask applies only while processing runs, so a single sub-block can be measured on its own. All enables stay on in the other phases, which keeps every memory reachable. A pass counter reports how many complete passes ran. A sticky flag records any external access attempted while the core owned the memory.

The external port has no handshake and accepts a request on any cycle. The tester may therefore pace load and readout at any rate slower than the processing rate.

Top module: `tharn_loop_ctrl`

## Requirements
- R1: After reset the phase is load (`phase_o` = 0), `cken_o` is all ones, and `core_go_o`, `done_o`, `err_o`, `mem_req_o` and `pass_cnt_o` are all zero.
- R2: In the load phase (0) and the readout phase (2), only the external port reaches the memory, and core requests are not forwarded. A read issued in one cycle returns its data on `ext_rdata_o` in the next cycle.
- R3: A `start_i` pulse in phase 0 or 2 enters the run phase (`phase_o` = 1) on the next cycle. On that same cycle it raises `core_go_o` for one cycle and clears `pass_cnt_o`, `done_o` and `err_o`.
- R4: With single-pass mode (`cfg_loop_i` = 0) configured, the first `core_done_i` moves the block to phase 2 on the next cycle. At that point `done_o` = 1, `pass_cnt_o` = 1, and no further `core_go_o` is issued.
- R5: In continuous mode (`cfg_loop_i` = 1), each `core_done_i` adds one to `pass_cnt_o` and raises `core_go_o` on the next cycle. The number of `core_go_o` pulses in a run equals the final count.
- R6: A `stop_i` pulse during a continuous run takes effect only at the next `core_done_i`. That pass is counted, and the final count is the count at the stop request plus one.
- R7: During phase 1, bit i of `cken_o` equals bit i of the configured mask. In every other phase, `cken_o` is all ones.
- R8: An external request during phase 1 is not forwarded to the memory and sets `err_o`. `err_o` stays set until the next accepted start.
- R9: Configuration writes (`cfg_we_i`) take effect only in phases 0 and 2. A write during phase 1 changes neither the mask nor the mode.
- R10: Results written by the core stay in memory after the run ends and can be read in phase 2. For a deterministic core, they are identical after every pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_loop_i | input | 1 | 1 = continuous, 0 = single pass |
| cfg_mask_i | input | NBLK | Per-sub-block clock-enable mask for the run phase |
| start_i | input | 1 | Start processing |
| stop_i | input | 1 | Stop request for continuous mode |
| ext_req_i | input | 1 | External memory request |
| ext_we_i | input | 1 | External write (1) or read (0) |
| ext_addr_i | input | AW | External address |
| ext_wdata_i | input | DW | External write data |
| ext_rdata_o | output | DW | External read data, one cycle after the request |
| core_go_o | output | 1 | One-cycle pass start to the core |
| core_done_i | input | 1 | One-cycle pass completion from the core |
| core_req_i | input | 1 | Core memory request |
| core_we_i | input | 1 | Core write (1) or read (0) |
| core_addr_i | input | AW | Core address |
| core_wdata_i | input | DW | Core write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data |
| cken_o | output | NBLK | Per-sub-block clock enables |
| phase_o | output | 2 | 0 load, 1 run, 2 readout |
| done_o | output | 1 | Run finished |
| err_o | output | 1 | Sticky blocked-access flag |
| pass_cnt_o | output | CNT_W | Completed passes in the current run |

## Verification
The bench issues a stop in the middle of a pass and expects the count at the request plus one. A controller that stopped at once would report one fewer pass and could leave partly written results in memory. It also writes to memory during a run, then reads the target address back afterwards. A design that let the write through would corrupt the input and set no error flag.

The bench rewrites the configuration in mid-run and expects the enables and looping to stay as they were. A design that accepted the write would gate the wrong sub-blocks or stop looping. It also checks that every pass writes the same results and that the enables return to all ones outside the run. Getting that wrong would leave memories unclocked during readout.

// File: rtl/tharn_pkg.sv
package tharn_pkg;
    typedef enum logic [1:0] {
        PH_LOAD = 2'd0,
        PH_RUN  = 2'd1,
        PH_READ = 2'd2
    } phase_e;
endpackage

// File: rtl/tharn_phase_fsm.sv
module tharn_phase_fsm
    import tharn_pkg::*;
#(
    parameter int NBLK  = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             cfg_we_i,
    input  logic             cfg_loop_i,
    input  logic [NBLK-1:0]  cfg_mask_i,
    input  logic             core_done_i,
    input  logic             ext_req_i,
    output phase_e           phase_o,
    output logic [NBLK-1:0]  mask_o,
    output logic             go_o,
    output logic             done_o,
    output logic             err_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        phase_e            phase;
        logic              loop;
        logic [NBLK-1:0]   mask;
        logic              stop_pend;
        logic              go;
        logic              done;
        logic              err;
        logic [CNT_W-1:0]  cnt;
    } st_t;

    st_t st_d, st_q;
    logic start_ok;

    assign start_ok = start_i && (st_q.phase != PH_RUN);

    always_comb begin
        st_d    = st_q;
        st_d.go = 1'b0;
        unique case (st_q.phase)
            PH_LOAD, PH_READ: begin
                if (cfg_we_i) begin
                    st_d.loop = cfg_loop_i;
                    st_d.mask = cfg_mask_i;
                end
                if (start_i) begin
                    st_d.phase     = PH_RUN;
                    st_d.go        = 1'b1;
                    st_d.cnt       = '0;
                    st_d.done      = 1'b0;
                    st_d.err       = 1'b0;
                    st_d.stop_pend = 1'b0;
                end
            end
            PH_RUN: begin
                if (stop_i)    st_d.stop_pend = 1'b1;
                if (ext_req_i) st_d.err       = 1'b1;
                if (core_done_i) begin
                    st_d.cnt = st_q.cnt + CNT_ONE;
                    if (!st_q.loop || st_q.stop_pend || stop_i) begin
                        st_d.phase = PH_READ;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.go = 1'b1;
                    end
                end
            end
            default: st_d.phase = PH_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase     <= PH_LOAD;
            st_q.loop      <= 1'b0;
            st_q.mask      <= '1;
            st_q.stop_pend <= 1'b0;
            st_q.go        <= 1'b0;
            st_q.done      <= 1'b0;
            st_q.err       <= 1'b0;
            st_q.cnt       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign mask_o  = st_q.mask;
    assign go_o    = st_q.go;
    assign done_o  = st_q.done;
    assign err_o   = st_q.err;
    assign cnt_o   = st_q.cnt;

    // R4
    single_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RUN && core_done_i && !st_q.loop) |=> (st_q.phase == PH_READ && st_q.done));
    // R3
    go_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.go |-> (st_q.phase == PH_RUN));
    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !start_ok) |=> st_q.err);
    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RUN && core_done_i) |=> (st_q.cnt == $past(st_q.cnt) + CNT_ONE));
    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RUN) |=> ($stable(st_q.mask) && $stable(st_q.loop)));
endmodule

// File: rtl/tharn_mem_arb.sv
module tharn_mem_arb #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          sel_core_i,
    input  logic          ext_req_i,
    input  logic          ext_we_i,
    input  logic [AW-1:0] ext_addr_i,
    input  logic [DW-1:0] ext_wdata_i,
    input  logic          core_req_i,
    input  logic          core_we_i,
    input  logic [AW-1:0] core_addr_i,
    input  logic [DW-1:0] core_wdata_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o
);
    always_comb begin
        if (sel_core_i) begin
            mem_req_o   = core_req_i;
            mem_we_o    = core_we_i;
            mem_addr_o  = core_addr_i;
            mem_wdata_o = core_wdata_i;
        end else begin
            mem_req_o   = ext_req_i;
            mem_we_o    = ext_we_i;
            mem_addr_o  = ext_addr_i;
            mem_wdata_o = ext_wdata_i;
        end
    end
endmodule

// File: rtl/tharn_cken_gen.sv
module tharn_cken_gen #(
    parameter int NBLK = 4
) (
    input  logic            run_i,
    input  logic [NBLK-1:0] mask_i,
    output logic [NBLK-1:0] cken_o
);
    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        assign cken_o[b] = !run_i || mask_i[b];
    end
endmodule

// File: rtl/tharn_loop_ctrl.sv
module tharn_loop_ctrl
    import tharn_pkg::*;
#(
    parameter int NBLK  = 4,
    parameter int AW    = 4,
    parameter int DW    = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we_i,
    input  logic             cfg_loop_i,
    input  logic [NBLK-1:0]  cfg_mask_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             ext_req_i,
    input  logic             ext_we_i,
    input  logic [AW-1:0]    ext_addr_i,
    input  logic [DW-1:0]    ext_wdata_i,
    output logic [DW-1:0]    ext_rdata_o,
    output logic             core_go_o,
    input  logic             core_done_i,
    input  logic             core_req_i,
    input  logic             core_we_i,
    input  logic [AW-1:0]    core_addr_i,
    input  logic [DW-1:0]    core_wdata_i,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [DW-1:0]    mem_wdata_o,
    input  logic [DW-1:0]    mem_rdata_i,
    output logic [NBLK-1:0]  cken_o,
    output logic [1:0]       phase_o,
    output logic             done_o,
    output logic             err_o,
    output logic [CNT_W-1:0] pass_cnt_o
);
    phase_e          phase;
    logic [NBLK-1:0] mask;
    logic            in_run;

    tharn_phase_fsm #(.NBLK(NBLK), .CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .cfg_we_i   (cfg_we_i),
        .cfg_loop_i (cfg_loop_i),
        .cfg_mask_i (cfg_mask_i),
        .core_done_i(core_done_i),
        .ext_req_i  (ext_req_i),
        .phase_o    (phase),
        .mask_o     (mask),
        .go_o       (core_go_o),
        .done_o     (done_o),
        .err_o      (err_o),
        .cnt_o      (pass_cnt_o)
    );

    assign in_run = (phase == PH_RUN);

    tharn_mem_arb #(.AW(AW), .DW(DW)) u_arb (
        .sel_core_i  (in_run),
        .ext_req_i   (ext_req_i),
        .ext_we_i    (ext_we_i),
        .ext_addr_i  (ext_addr_i),
        .ext_wdata_i (ext_wdata_i),
        .core_req_i  (core_req_i),
        .core_we_i   (core_we_i),
        .core_addr_i (core_addr_i),
        .core_wdata_i(core_wdata_i),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o)
    );

    tharn_cken_gen #(.NBLK(NBLK)) u_cken (
        .run_i (in_run),
        .mask_i(mask),
        .cken_o(cken_o)
    );

    assign ext_rdata_o = mem_rdata_i;
    assign phase_o     = phase;

    // R7
    cken_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 2'd1) |-> (&cken_o));
    // R8
    ext_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd1 && !core_req_i) |-> !mem_req_o);
    // R2
    core_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 2'd1 && !ext_req_i) |-> !mem_req_o);
endmodule

// File: tb/tharn_loop_ctrl_tb_top.sv
module tharn_loop_ctrl_tb_top;
    localparam int NBLK = 4, AW = 4, DW = 8, CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic cfg_we = 0, cfg_loop = 0, start = 0, stop = 0;
    logic [NBLK-1:0] cfg_mask = '0;
    logic ext_req = 0, ext_we = 0;
    logic [AW-1:0] ext_addr = '0;
    logic [DW-1:0] ext_wdata = '0;
    logic [DW-1:0] ext_rdata, mem_rdata, mem_wdata, core_wdata;
    logic core_go, core_done, core_req, core_we;
    logic [AW-1:0] core_addr, mem_addr;
    logic mem_req, mem_we;
    logic [NBLK-1:0] cken;
    logic [1:0] phase;
    logic done, err;
    logic [CNT_W-1:0] pass_cnt;

    tharn_loop_ctrl #(.NBLK(NBLK), .AW(AW), .DW(DW), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_loop_i(cfg_loop),
        .cfg_mask_i(cfg_mask), .start_i(start), .stop_i(stop),
        .ext_req_i(ext_req), .ext_we_i(ext_we), .ext_addr_i(ext_addr),
        .ext_wdata_i(ext_wdata), .ext_rdata_o(ext_rdata), .core_go_o(core_go),
        .core_done_i(core_done), .core_req_i(core_req), .core_we_i(core_we),
        .core_addr_i(core_addr), .core_wdata_i(core_wdata), .mem_req_o(mem_req),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata), .cken_o(cken), .phase_o(phase), .done_o(done),
        .err_o(err), .pass_cnt_o(pass_cnt)
    );

    // memory model, one-cycle read latency
    logic [DW-1:0] mem [16];
    always_ff @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
    end

    function automatic logic [DW-1:0] xf(input logic [DW-1:0] x);
        return (x ^ 8'h5A) + 8'd3;
    endfunction

    logic [DW-1:0] inp [4];

    // deterministic core model
    typedef enum logic [1:0] {C_IDLE, C_RD, C_WR, C_DN} cst_e;
    cst_e cst;
    logic [1:0] cidx;
    logic poke = 0;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cst <= C_IDLE; cidx <= '0;
        end else begin
            unique case (cst)
                C_IDLE: if (core_go) begin cst <= C_RD; cidx <= '0; end
                C_RD:   cst <= C_WR;
                C_WR:   begin cidx <= cidx + 2'd1; cst <= (cidx == 2'd3) ? C_DN : C_RD; end
                default: cst <= C_IDLE;
            endcase
        end
    end
    assign core_done  = (cst == C_DN);
    assign core_req   = (cst == C_RD) || (cst == C_WR) || poke;
    assign core_we    = (cst == C_WR) || poke;
    assign core_addr  = poke ? 4'd0 : ((cst == C_WR) ? (4'd4 + 4'(cidx)) : 4'(cidx));
    assign core_wdata = poke ? 8'hFF : xf(mem_rdata);

    int errors = 0, checks = 0, go_seen = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) if (rst_n && core_go) go_seen++;

    // R5 R10: every core write in every pass carries the same result
    always @(negedge clk) begin
        if (rst_n && cst == C_WR)
            chk(core_wdata == xf(inp[cidx]), "R10 core result per pass", core_wdata, xf(inp[cidx]));
    end

    // scoreboard for external reads
    logic [DW-1:0] exp_q [$];
    string tag_q [$];
    logic rd_tag = 0;
    always begin
        @(posedge clk); #1;
        if (rd_tag) begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(ext_rdata == e, t, ext_rdata, e);
        end
    end

    task automatic ext_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); ext_req = 1; ext_we = 1; ext_addr = a; ext_wdata = d;
        @(negedge clk); ext_req = 0; ext_we = 0;
    endtask

    task automatic ext_read(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
        @(negedge clk); ext_req = 1; ext_we = 0; ext_addr = a; rd_tag = 1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); ext_req = 0; rd_tag = 0;
    endtask

    task automatic cfg(input logic lp, input logic [NBLK-1:0] m);
        @(negedge clk); cfg_we = 1; cfg_loop = lp; cfg_mask = m;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic wait_read();
        for (int i = 0; i < 2000 && phase != 2'd2; i++) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int c0, g0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(phase == 2'd0, "R1 phase", phase, 0);
        chk(cken == 4'hF, "R1 cken", cken, 4'hF);
        chk(!core_go && !done && !err && !mem_req, "R1 flags", {core_go, done, err, mem_req}, 0);
        chk(pass_cnt == 0, "R1 count", pass_cnt, 0);

        for (int i = 0; i < 4; i++) begin
            inp[i] = 8'h13 * (i + 1);
            ext_write(AW'(i), inp[i]);
        end
        // R2: core request in load phase is not forwarded
        @(negedge clk); poke = 1; #1;
        chk(mem_req == 1'b0, "R2 core blocked in load", mem_req, 0);
        @(negedge clk); poke = 0;
        ext_read(4'd0, inp[0], "R2 load readback");

        // single pass
        cfg(1'b0, 4'b0101);
        g0 = go_seen;
        pulse_start();
        chk(phase == 2'd1 && core_go, "R3 enter run with go", {phase, core_go}, 3'b011);
        chk(cken == 4'b0101, "R7 mask in run", cken, 4'b0101);
        wait_read();
        @(negedge clk);
        chk(done == 1'b1, "R4 done flag", done, 1);
        chk(pass_cnt == 1, "R4 single count", pass_cnt, 1);
        chk(go_seen - g0 == 1, "R4 single go count", go_seen - g0, 1);
        chk(cken == 4'hF, "R7 all on in readout", cken, 4'hF);
        for (int i = 0; i < 4; i++) ext_read(AW'(4 + i), xf(inp[i]), "R10 readout single");

        // continuous run
        cfg(1'b1, 4'b0010);
        g0 = go_seen;
        pulse_start();
        chk(!done && !err && pass_cnt == 0, "R3 cleared on start", {done, err, pass_cnt}, 0);
        chk(cken == 4'b0010, "R7 mask second run", cken, 4'b0010);
        @(negedge clk); ext_req = 1; ext_we = 1; ext_addr = 4'd0; ext_wdata = 8'h00; #1;
        chk(!(mem_req && mem_we && mem_addr == 4'd0), "R8 ext write not forwarded", mem_req, 0);
        @(negedge clk); ext_req = 0; ext_we = 0;
        chk(err == 1'b1, "R8 error set", err, 1);
        cfg(1'b0, 4'b1111);
        chk(cken == 4'b0010, "R9 mask held in run", cken, 4'b0010);
        for (int i = 0; i < 3000 && pass_cnt < 3; i++) @(negedge clk);
        chk(phase == 2'd1, "R9 loop mode held", phase, 1);
        for (int i = 0; i < 50 && cst != C_RD; i++) @(negedge clk);
        c0 = pass_cnt;
        stop = 1;
        @(negedge clk); stop = 0;
        chk(phase == 2'd1, "R6 stop deferred", phase, 1);
        wait_read();
        @(negedge clk);
        chk(pass_cnt == c0 + 1, "R6 final count", pass_cnt, c0 + 1);
        chk(go_seen - g0 == pass_cnt, "R5 go pulses match count", go_seen - g0, pass_cnt);
        chk(err == 1'b1, "R8 error sticky", err, 1);
        ext_read(4'd0, inp[0], "R8 input untouched");
        for (int i = 0; i < 4; i++) ext_read(AW'(4 + i), xf(inp[i]), "R10 readout loop");

        // configuration accepted in readout phase
        cfg(1'b0, 4'b1000);
        pulse_start();
        chk(cken == 4'b1000, "R9 cfg in readout applied", cken, 4'b1000);
        chk(err == 1'b0, "R3 error cleared", err, 0);
        wait_read();
        @(negedge clk);
        chk(pass_cnt == 1, "R9 single mode applied", pass_cnt, 1);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule